// File: doc/BRIEF.md
# Multi-Width SIMD Field ALU

This block is a single-stage 128-bit SIMD execution unit. Each instruction brings an opcode, a field-width code, an 8-bit immediate and three 128-bit operands (a, b, c). It produces one 128-bit result. The result is split into independent lanes of 2, 4, 8, 16, 32, 64 or 128 bits, and every lane is computed on its own. No bit ever crosses a lane boundary.

The unit offers:
- a per-lane rotate-left by a variable count taken from operand b;
- per-lane logical left and right shifts by the immediate;
- a broadcast of the immediate into every lane;
- a per-lane add and subtract that wrap;
- a bitwise three-input select.

Instructions arrive on a valid/ready stream and leave on another, with one register stage between them. The input side is ready whenever the output register is empty or is being drained in the same cycle. When the consumer holds `out_ready` high, one instruction is accepted every cycle with no stalls. When the consumer holds `out_ready` low, the result stays on the output unchanged and the producer is stalled.

Top module: `simd_field_alu`

## Requirements
- R1: An instruction accepted on a clock edge (in_valid and in_ready both high) shows up on out_valid/out_data right after that edge. Back-to-back instructions give back-to-back results.
- R2: Back-pressure rules:
  - in_ready is high exactly when out_valid is low or out_ready is high.
  - While out_valid is high and out_ready is low, out_data and out_valid hold.
  - A result that is consumed with no new instruction accepted clears out_valid.
- R3: Width code encoding. Code k selects lanes of 2^(k+1) bits: code 0 is 2 bits, 1 is 4, 2 is 8, 3 is 16, 4 is 32, 5 is 64 and 6 is 128. Code 7 gives an all-zero result for every opcode.
- R4: Opcode 2 (rotate-left) rotates each lane of a left by the value in the same lane of b. Only the low log2(lane width) bits of that value are used, so the count is taken modulo the lane width.
- R5: Opcode 3 (shift left) and opcode 4 (logical shift right) shift each lane of a by the immediate, filling with zeros. An immediate equal to or greater than the lane width gives an all-zero lane.
- R6: Opcode 5 (broadcast) writes the immediate into every lane. For lanes narrower than 8 bits the immediate is cut to its low bits; for wider lanes it is zero-extended.
- R7: Opcode 6 (select) computes (a AND b) OR (NOT a AND c) over all 128 bits. The result is the same for every legal width code.
- R8: Opcode 0 (add) and opcode 1 (subtract, a minus b) wrap modulo 2^n in each n-bit lane. No carry or borrow passes between lanes.
- R9: Opcode 7 is reserved and gives an all-zero result.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can take an instruction |
| in_op | input | 3 | Opcode |
| in_wcode | input | 3 | Lane width code |
| in_imm | input | 8 | Shift amount or broadcast constant |
| in_a | input | 128 | Operand a |
| in_b | input | 128 | Operand b (addend, count, or select value) |
| in_c | input | 128 | Operand c (select only) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Result |

## Verification
Each lane-wise opcode is driven at all seven width codes. The operands are chosen so that a lane overflowing or a shift spilling over would corrupt its neighbour; this separates true per-lane partitioning from a plain 128-bit operation. Rotate counts include values at and above the lane width, and shift immediates include one below the width, the width itself and a large value; these separate modulo handling and zero fill from wrong truncation. Select is tried with mixed masks at several width codes, and the reserved width code and opcode are also applied. A stalled consumer and back-to-back issue cover the stream rules.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DATA_W = 128;
  localparam int IMM_W  = 8;
  localparam int NUM_WIDTHS = 7;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_ROTL  = 3'd2,
    OP_SHL   = 3'd3,
    OP_SHR   = 3'd4,
    OP_BCAST = 3'd5,
    OP_SEL   = 3'd6,
    OP_RSVD  = 3'd7
  } simd_op_e;
endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
  import simd_pkg::*;
#(
  parameter int LW   = 8,
  parameter int IMMW = 8
) (
  input  simd_op_e        op,
  input  logic [LW-1:0]   a,
  input  logic [LW-1:0]   b,
  input  logic [IMMW-1:0] imm,
  output logic [LW-1:0]   y
);
  localparam int CNT_W = (LW > 2) ? $clog2(LW) : 1;
  localparam logic [IMMW:0] LW_LIM = (IMMW+1)'(LW);

  logic [CNT_W-1:0]   rot_cnt;
  logic [2*LW-1:0]    rot_dbl;
  logic [LW+IMMW-1:0] imm_ext;
  logic               shift_out;

  assign rot_cnt   = b[CNT_W-1:0];
  assign rot_dbl   = {a, a} << rot_cnt;
  assign imm_ext   = {{LW{1'b0}}, imm};
  assign shift_out = ({1'b0, imm} >= LW_LIM);

  always_comb begin
    unique case (op)
      OP_ADD:   y = a + b;
      OP_SUB:   y = a - b;
      OP_ROTL:  y = rot_dbl[2*LW-1:LW];
      OP_SHL:   y = shift_out ? '0 : (a << imm);
      OP_SHR:   y = shift_out ? '0 : (a >> imm);
      OP_BCAST: y = imm_ext[LW-1:0];
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/simd_width_slice.sv
module simd_width_slice
  import simd_pkg::*;
#(
  parameter int DW   = 128,
  parameter int LW   = 8,
  parameter int IMMW = 8
) (
  input  simd_op_e        op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [IMMW-1:0] imm,
  output logic [DW-1:0]   y
);
  localparam int LANES = DW / LW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    simd_lane_unit #(.LW(LW), .IMMW(IMMW)) u_lane (
      .op  (op),
      .a   (a[l*LW +: LW]),
      .b   (b[l*LW +: LW]),
      .imm (imm),
      .y   (y[l*LW +: LW])
    );
  end
endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_accept_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: rtl/simd_field_alu.sv
module simd_field_alu
  import simd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_op,
  input  logic [2:0]         in_wcode,
  input  logic [IMM_W-1:0]   in_imm,
  input  logic [DATA_W-1:0]  in_a,
  input  logic [DATA_W-1:0]  in_b,
  input  logic [DATA_W-1:0]  in_c,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data
);
  simd_op_e          op;
  logic [DATA_W-1:0] slice_y [NUM_WIDTHS];
  logic [DATA_W-1:0] sel_y;
  logic [DATA_W-1:0] res;

  assign op    = simd_op_e'(in_op);
  assign sel_y = (in_a & in_b) | (~in_a & in_c);

  for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_width
    simd_width_slice #(.DW(DATA_W), .LW(2 << w), .IMMW(IMM_W)) u_slice (
      .op  (op),
      .a   (in_a),
      .b   (in_b),
      .imm (in_imm),
      .y   (slice_y[w])
    );
  end

  always_comb begin
    if (in_wcode >= 3'(NUM_WIDTHS)) res = '0;
    else if (op == OP_SEL)          res = sel_y;
    else                            res = slice_y[in_wcode];
  end

  simd_out_stage #(.DW(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  p_bad_width_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_wcode == 3'd7 |=> out_data == '0);
  p_rsvd_op_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 3'd7 |=> out_data == '0);
  p_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 3'd6 && in_wcode != 3'd7
    |=> out_data == $past((in_a & in_b) | (~in_a & in_c)));
endmodule

// File: tb/simd_field_alu_tb.sv
module simd_field_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_op = '0;
  logic [2:0]   in_wcode = '0;
  logic [7:0]   in_imm = '0;
  logic [127:0] in_a = '0, in_b = '0, in_c = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_field_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wcode(in_wcode), .in_imm(in_imm),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  localparam logic [127:0] PAT_A = 128'hFFFF_0001_8000_7FFF_DEAD_BEEF_0123_4567;
  localparam logic [127:0] PAT_B = 128'h0001_FFFF_8000_0001_5A5A_C3C3_FEDC_BA98;
  localparam logic [127:0] PAT_C = 128'h0F0F_F0F0_1234_5678_9ABC_DEF0_AAAA_5555;

  function automatic logic [127:0] model(input logic [2:0] op, input logic [2:0] wc,
      input logic [7:0] imm, input logic [127:0] a, input logic [127:0] b,
      input logic [127:0] c);
    logic [127:0] acc, mask, fa, fb, r;
    int fw, cnt;
    if (wc == 3'd7 || op == 3'd7) return '0;
    if (op == 3'd6) return (a & b) | (~a & c);
    fw   = 2 << wc;
    mask = {128{1'b1}} >> (128 - fw);
    acc  = '0;
    for (int f = 0; f < 128 / fw; f++) begin
      fa  = (a >> (f * fw)) & mask;
      fb  = (b >> (f * fw)) & mask;
      cnt = int'(fb[6:0]) % fw;
      case (op)
        3'd0: r = (fa + fb) & mask;
        3'd1: r = (fa - fb) & mask;
        3'd2: r = (cnt == 0) ? fa : (((fa << cnt) | (fa >> (fw - cnt))) & mask);
        3'd3: r = (int'(imm) >= fw) ? '0 : ((fa << imm) & mask);
        3'd4: r = (int'(imm) >= fw) ? '0 : (fa >> imm);
        default: r = 128'(imm) & mask;
      endcase
      acc = acc | (r << (f * fw));
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [2:0] wc, input logic [7:0] imm,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] c, input string tag);
    logic [127:0] exp;
    exp = model(op, wc, imm, a, b, c);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_wcode = wc; in_imm = imm;
    in_a = a; in_b = b; in_c = c;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_data === exp, tag, out_data, exp);
  endtask

  task automatic t_reset;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R10 reset state",
          {126'd0, out_valid, in_ready}, 128'd1);
  endtask

  task automatic t_add_sub;
    for (int w = 0; w < 7; w++) begin
      run_op(3'd0, 3'(w), 8'd0, PAT_A, PAT_B, '0, $sformatf("R8 add w%0d", w));
      run_op(3'd1, 3'(w), 8'd0, PAT_A, PAT_B, '0, $sformatf("R8 sub w%0d", w));
    end
  endtask

  task automatic t_rotl;
    for (int w = 0; w < 7; w++)
      run_op(3'd2, 3'(w), 8'd0, PAT_A, PAT_B, '0, $sformatf("R4 rotl w%0d", w));
    run_op(3'd2, 3'd2, 8'd0, PAT_A, {16{8'd11}}, '0, "R4 rotl count above width");
  endtask

  task automatic t_shifts;
    for (int w = 0; w < 7; w++) begin
      int fw = 2 << w;
      run_op(3'd3, 3'(w), 8'd1, PAT_A, '0, '0, $sformatf("R5 shl1 w%0d", w));
      run_op(3'd4, 3'(w), 8'(fw - 1), PAT_A, '0, '0, $sformatf("R5 shr max w%0d", w));
      run_op(3'd4, 3'(w), 8'(fw), PAT_A, '0, '0, $sformatf("R5 shr=width w%0d", w));
    end
    run_op(3'd3, 3'd6, 8'd200, PAT_A, '0, '0, "R5 shl large imm");
  endtask

  task automatic t_bcast;
    for (int w = 0; w < 7; w++)
      run_op(3'd5, 3'(w), 8'hA7, '0, '0, '0, $sformatf("R6 bcast w%0d", w));
  endtask

  task automatic t_select;
    run_op(3'd6, 3'd0, 8'd0, PAT_A, PAT_B, PAT_C, "R7 sel w0");
    run_op(3'd6, 3'd6, 8'd0, PAT_C, PAT_A, PAT_B, "R7 sel w6");
  endtask

  task automatic t_illegal;
    run_op(3'd0, 3'd7, 8'd3, PAT_A, PAT_B, PAT_C, "R3 width code 7 add");
    run_op(3'd6, 3'd7, 8'd3, PAT_A, PAT_B, PAT_C, "R3 width code 7 sel");
    run_op(3'd7, 3'd2, 8'd3, PAT_A, PAT_B, PAT_C, "R9 reserved opcode");
  endtask

  task automatic t_stream;
    logic [127:0] e1, e2;
    e1 = model(3'd0, 3'd2, 8'd0, PAT_A, PAT_B, '0);
    e2 = model(3'd1, 3'd3, 8'd0, PAT_B, PAT_A, '0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 3'd0; in_wcode = 3'd2; in_a = PAT_A; in_b = PAT_B;
    @(negedge clk);
    check(out_valid === 1'b1 && out_data === e1, "R1 first result", out_data, e1);
    check(in_ready === 1'b0, "R2 not ready when stalled", {127'd0, in_ready}, '0);
    in_op = 3'd1; in_wcode = 3'd3; in_a = PAT_B; in_b = PAT_A;
    @(negedge clk);
    check(out_valid === 1'b1 && out_data === e1, "R2 held under stall", out_data, e1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_data === e2, "R1 R2 next after release", out_data, e2);
    @(negedge clk);
    check(out_valid === 1'b0, "R2 drained", {127'd0, out_valid}, '0);
    // back-to-back issue
    in_valid = 1'b1; in_op = 3'd0; in_wcode = 3'd2; in_a = PAT_A; in_b = PAT_B;
    @(negedge clk);
    check(out_valid === 1'b1 && out_data === e1, "R1 back-to-back 1", out_data, e1);
    in_op = 3'd1; in_wcode = 3'd3; in_a = PAT_B; in_b = PAT_A;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_data === e2, "R1 back-to-back 2", out_data, e2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add_sub();
    t_rotl();
    t_shifts();
    t_bcast();
    t_select();
    t_illegal();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule